// File: doc/BRIEF.md
# Neighbor Timing-Error Averaging Node

This block belongs to one node of a rectangular grid of digitally controlled oscillators that keep each other in step. Each node measures a signed timing error against each of its nearest neighbors: north, east, south and west. The block merges those link errors into one total error for the node's loop filter. A node in the middle of the grid has four neighbors, a node on an edge has three, and a corner node has two. A grid with holes can leave any subset of the four links missing.

The loop filter runs on the node's own clock edge. At that moment a link whose neighbor edge has not arrived yet (a positive error, meaning the local clock leads) has no fresh measurement. For such a link the block substitutes the error it captured at the previous local edge. Links that lag or are exactly aligned use their current error. The block sums the chosen errors over the links that are present and divides by the number of those links, which gives the averaged effective error. It also forms the plain mean of the current errors (the averaged true error), which one filter variant needs for its delayed term.

A static presence mask selects the links. A mask with fewer than two links is not a valid grid position. For such a mask the block drives zero averages and raises a configuration error flag.

Top module: `nbr_err_avg`

## Requirements
- R1: While rst_n is low and after it rises, eff_avg, true_avg and cfg_err are 0, and the stored previous error of every link is 0.
- R2: For link i (bit i of link_present and slice [i*12 +: 12] of link_err; 0 north, 1 east, 2 south, 3 west), the effective error is the current link error if it is less than or equal to zero. Otherwise it is the link error captured at the most recent earlier strobe.
- R3: The stored previous error of each link is loaded from link_err only on a clock edge where edge_stb is 1. Changes to link_err between strobes do not reach it.
- R4: true_avg is the mean of the current errors of the present links, rounded the same way as eff_avg.
- R5: With four links present, each average is the sum shifted right arithmetically by two, which is the floor of sum/4.
- R6: With two links present, each average is the sum shifted right arithmetically by one, which is the floor of sum/2.
- R7: With three links present, each average is sum/3 rounded to the nearest integer.
- R8: A link whose presence bit is 0 contributes nothing to either sum or to the count, whatever its error value.
- R9: When fewer than two presence bits are set, cfg_err is 1 one cycle later, and a strobe loads 0 into both averages. cfg_err follows the mask with one cycle of delay.
- R10: eff_avg and true_avg change only on the clock edge that samples edge_stb at 1. They hold their values at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Node clock |
| rst_n | input | 1 | Synchronous reset, active low |
| edge_stb | input | 1 | One-cycle pulse marking the local oscillator edge |
| link_present | input | 4 | Static presence mask, one bit per link |
| link_err | input | 48 | Four signed 12-bit link errors, link i at bits [i*12 +: 12] |
| eff_avg | output | 12 | Averaged effective (lead/lag substituted) error, signed |
| true_avg | output | 12 | Averaged current error, signed |
| cfg_err | output | 1 | Presence mask has fewer than two links |

## Verification
The main internal state is the per-link history register. A wrong value there shows only in eff_avg, and only on a strobe where that link leads. The bench therefore drives leading links right after strobes with known values, and after idle cycles in which link_err was changed, so a history error shows on the next strobe's output. A wrong count decode or divider variant shows as a mismatch of true_avg at the first strobe under the affected mask. A bad-mask error shows as a nonzero average or a missing cfg_err one cycle after the mask is applied.

// File: rtl/nbr_avg_pkg.sv
// Package: shared constants and types of the neighbor error averaging node.
// Assumes a four-link rectangular grid node.
package nbr_avg_pkg;
    localparam int NLINK = 4;

    // Decoded number of present links; NONE covers every invalid mask.
    typedef enum logic [1:0] {
        CNT_NONE  = 2'd0,
        CNT_TWO   = 2'd1,
        CNT_THREE = 2'd2,
        CNT_FOUR  = 2'd3
    } nbr_cnt_e;
endpackage

// File: rtl/nbr_link_hist.sv
// Module: per-link history and lead/lag substitution.
// Keeps the error seen at the last local-edge strobe for each link. Outputs
// the effective error: the current value when it is <= 0, else the stored one.
// Assumes edge_stb is a single-cycle pulse per local edge.
module nbr_link_hist #(
    parameter int ERR_W = 12,
    parameter int NL    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_stb,
    input  logic [NL*ERR_W-1:0] cur_flat,
    output logic [NL*ERR_W-1:0] eff_flat
);
    for (genvar i = 0; i < NL; i++) begin : g_link
        logic signed [ERR_W-1:0] cur_v;
        logic signed [ERR_W-1:0] prev_q;

        assign cur_v = cur_flat[i*ERR_W +: ERR_W];

        // History register: capture the link error at each local edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= '0;
            end else if (edge_stb) begin
                prev_q <= cur_v;
            end
        end

        // Substitution: a leading link (positive error) uses the stored value.
        always_comb begin
            if (cur_v > 0) begin
                eff_flat[i*ERR_W +: ERR_W] = prev_q;
            end else begin
                eff_flat[i*ERR_W +: ERR_W] = cur_v;
            end
        end
    end
endmodule

// File: rtl/nbr_presence_dec.sv
// Module: presence mask decoder.
// Counts the set bits of the static link mask and maps the count to a divisor
// code. A count below two is flagged as an invalid grid position.
module nbr_presence_dec
    import nbr_avg_pkg::*;
#(
    parameter int NL = 4
) (
    input  logic [NL-1:0] mask,
    output nbr_cnt_e      cnt,
    output logic          bad
);
    localparam int CW = $clog2(NL + 1);

    logic [CW-1:0] ones;

    // Population count of the presence mask.
    always_comb begin
        ones = '0;
        for (int i = 0; i < NL; i++) begin
            ones = ones + CW'(mask[i]);
        end
    end

    // Map the count onto the divisor variants.
    always_comb begin
        case (ones)
            CW'(2):  cnt = CNT_TWO;
            CW'(3):  cnt = CNT_THREE;
            CW'(4):  cnt = CNT_FOUR;
            default: cnt = CNT_NONE;
        endcase
        bad = (ones < CW'(2));
    end
endmodule

// File: rtl/nbr_mean_div.sv
// Module: normalizer dividing a signed link sum by the neighbor count.
// Count 2 and 4 use arithmetic right shifts (floor). Count 3 multiplies by a
// fixed-point reciprocal and rounds to nearest. The result is assumed to fit
// ERR_W bits, since it is a mean of ERR_W-bit values.
module nbr_mean_div
    import nbr_avg_pkg::*;
#(
    parameter int ERR_W  = 12,
    parameter int SUM_W  = 14,
    parameter int FRAC_W = 16
) (
    input  logic signed [SUM_W-1:0] sum,
    input  nbr_cnt_e                cnt,
    output logic signed [ERR_W-1:0] avg
);
    localparam int PROD_W = SUM_W + FRAC_W + 2;
    localparam int RECIP  = ((1 << FRAC_W) + 1) / 3;

    logic signed [PROD_W-1:0] sum_x;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] rnd;
    logic signed [ERR_W-1:0]  q2;
    logic signed [ERR_W-1:0]  q3;
    logic signed [ERR_W-1:0]  q4;

    // Reciprocal path for three neighbors with a half-LSB rounding offset.
    always_comb begin
        sum_x = PROD_W'(sum);
        prod  = sum_x * $signed(PROD_W'(RECIP));
        rnd   = prod + (PROD_W'(1) <<< (FRAC_W - 1));
        q3    = ERR_W'(rnd >>> FRAC_W);
    end

    // Shift paths for two and four neighbors.
    always_comb begin
        q2 = ERR_W'(sum >>> 1);
        q4 = ERR_W'(sum >>> 2);
    end

    // Variant select by decoded count.
    always_comb begin
        case (cnt)
            CNT_TWO:   avg = q2;
            CNT_THREE: avg = q3;
            CNT_FOUR:  avg = q4;
            default:   avg = '0;
        endcase
    end
endmodule

// File: rtl/nbr_err_avg.sv
// Module: neighbor timing-error averaging node (top).
// Combines up to four signed link errors into an averaged effective error
// (lead/lag substituted per link) and an averaged current error. The results
// are registered on the edge that samples edge_stb. Assumes link_present is
// static during operation. The reset is synchronous and active low.
module nbr_err_avg
    import nbr_avg_pkg::*;
#(
    parameter int ERR_W  = 12,
    parameter int FRAC_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   edge_stb,
    input  logic [NLINK-1:0]       link_present,
    input  logic [NLINK*ERR_W-1:0] link_err,
    output logic [ERR_W-1:0]       eff_avg,
    output logic [ERR_W-1:0]       true_avg,
    output logic                   cfg_err
);
    localparam int SUM_W = ERR_W + $clog2(NLINK);

    logic [NLINK*ERR_W-1:0]  eff_flat;
    logic signed [SUM_W-1:0] eff_sum;
    logic signed [SUM_W-1:0] true_sum;
    logic signed [ERR_W-1:0] eff_mean;
    logic signed [ERR_W-1:0] true_mean;
    nbr_cnt_e                cnt;
    logic                    bad;

    nbr_link_hist #(.ERR_W(ERR_W), .NL(NLINK)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_stb (edge_stb),
        .cur_flat (link_err),
        .eff_flat (eff_flat)
    );

    nbr_presence_dec #(.NL(NLINK)) u_dec (
        .mask (link_present),
        .cnt  (cnt),
        .bad  (bad)
    );

    // Masked sums over present links, sign-extended to the guard width.
    always_comb begin
        eff_sum  = '0;
        true_sum = '0;
        for (int i = 0; i < NLINK; i++) begin
            if (link_present[i]) begin
                eff_sum  = eff_sum  + SUM_W'($signed(eff_flat[i*ERR_W +: ERR_W]));
                true_sum = true_sum + SUM_W'($signed(link_err[i*ERR_W +: ERR_W]));
            end
        end
    end

    nbr_mean_div #(.ERR_W(ERR_W), .SUM_W(SUM_W), .FRAC_W(FRAC_W)) u_div_eff (
        .sum (eff_sum),
        .cnt (cnt),
        .avg (eff_mean)
    );

    nbr_mean_div #(.ERR_W(ERR_W), .SUM_W(SUM_W), .FRAC_W(FRAC_W)) u_div_true (
        .sum (true_sum),
        .cnt (cnt),
        .avg (true_mean)
    );

    // Result registers: load on the strobed edge, zero for an invalid mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_avg  <= '0;
            true_avg <= '0;
        end else if (edge_stb) begin
            eff_avg  <= bad ? '0 : eff_mean;
            true_avg <= bad ? '0 : true_mean;
        end
    end

    // Configuration flag: registered copy of the mask check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= bad;
        end
    end
endmodule

// File: rtl/nbr_err_avg_chk.sv
// Checker: port-level properties of the averaging node, bound to the top.
module nbr_err_avg_chk
    import nbr_avg_pkg::*;
#(
    parameter int ERR_W = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   edge_stb,
    input logic [NLINK-1:0]       link_present,
    input logic [NLINK*ERR_W-1:0] link_err,
    input logic [ERR_W-1:0]       eff_avg,
    input logic [ERR_W-1:0]       true_avg,
    input logic                   cfg_err
);
    logic signed [ERR_W+1:0] raw_sum;
    logic                    all_lag;

    always_comb begin
        raw_sum = '0;
        all_lag = 1'b1;
        for (int i = 0; i < NLINK; i++) begin
            raw_sum = raw_sum + (ERR_W+2)'($signed(link_err[i*ERR_W +: ERR_W]));
            if ($signed(link_err[i*ERR_W +: ERR_W]) > 0) all_lag = 1'b0;
        end
    end

    // R10: averages hold when no strobe is sampled
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_stb |=> ($stable(eff_avg) && $stable(true_avg)));

    // R9: an invalid mask on a strobe yields zero averages
    a_r9_bad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_stb && $countones(link_present) < 2) |=> (eff_avg == '0 && true_avg == '0));

    // R9: the flag follows the mask one cycle later
    a_r9_flag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cfg_err == ($countones($past(link_present)) < 2)));

    // R2: when every link lags, the substituted and true means agree
    a_r2_all_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_stb && all_lag) |=> (eff_avg == true_avg));

    // R5: four links give the floor of the quarter sum
    a_r5_four: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_stb && link_present == 4'hF) |=> (true_avg == $past(ERR_W'(raw_sum >>> 2))));
endmodule

bind nbr_err_avg nbr_err_avg_chk #(.ERR_W(ERR_W)) u_chk (.*);

// File: tb/nbr_err_avg_tb.sv
// Bench: directed scenarios for the neighbor error averaging node.
module nbr_err_avg_tb_top;
    localparam int W = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          edge_stb = 1'b0;
    logic [3:0]    link_present = 4'hF;
    logic [4*W-1:0] link_err = '0;
    logic [W-1:0]  eff_avg;
    logic [W-1:0]  true_avg;
    logic          cfg_err;

    int tests = 0;
    int fails = 0;
    int prev_m [4];

    always #4 clk = ~clk;

    nbr_err_avg dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .edge_stb     (edge_stb),
        .link_present (link_present),
        .link_err     (link_err),
        .eff_avg      (eff_avg),
        .true_avg     (true_avg),
        .cfg_err      (cfg_err)
    );

    function automatic int fdiv(input int a, input int b);
        int q;
        q = a / b;
        if ((a % b != 0) && (a < 0)) q = q - 1;
        return q;
    endfunction

    function automatic int mean_of(input int s, input int c);
        if (c == 2) return fdiv(s, 2);
        if (c == 4) return fdiv(s, 4);
        if (c == 3) return fdiv(2 * s + 3, 6);
        return 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_err(input int e0, input int e1, input int e2, input int e3);
        link_err = {W'(e3), W'(e2), W'(e1), W'(e0)};
    endtask

    // Apply one strobe with the given errors and mask, then check all outputs.
    task automatic strobe_chk(input int e0, input int e1, input int e2, input int e3,
                              input logic [3:0] m, input string req);
        int e [4];
        int se, st, c;
        e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
        se = 0; st = 0; c = 0;
        for (int i = 0; i < 4; i++) begin
            if (m[i]) begin
                c++;
                st += e[i];
                se += (e[i] > 0) ? prev_m[i] : e[i];
            end
        end
        @(negedge clk);
        set_err(e0, e1, e2, e3);
        link_present = m;
        edge_stb = 1'b1;
        @(negedge clk);
        edge_stb = 1'b0;
        check({req, " eff"}, $signed(eff_avg), (c < 2) ? 0 : mean_of(se, c));
        check({req, " true"}, $signed(true_avg), (c < 2) ? 0 : mean_of(st, c));
        check({req, " cfg_err"}, int'(cfg_err), (c < 2) ? 1 : 0);
        for (int i = 0; i < 4; i++) prev_m[i] = e[i];
    endtask

    task automatic t_reset();
        check("R1 eff reset", $signed(eff_avg), 0);
        check("R1 true reset", $signed(true_avg), 0);
        check("R1 cfg reset", int'(cfg_err), 0);
        // R1: leading links right after reset substitute a zero history
        strobe_chk(40, 80, 120, 160, 4'hF, "R1 zero history");
    endtask

    task automatic t_four();
        strobe_chk(-5, -6, -7, -9, 4'hF, "R5 floor quarter");
        strobe_chk(-2048, -2048, -2048, -2048, 4'hF, "R5 min");
        strobe_chk(0, 0, 0, 0, 4'hF, "R2 zero lags");
    endtask

    task automatic t_substitute();
        strobe_chk(100, 200, -300, 400, 4'hF, "R2 prime");
        strobe_chk(7, 9, -11, 13, 4'hF, "R2 lead uses prev");
        strobe_chk(2047, 2047, 2047, 2047, 4'hF, "R2 max prime");
        strobe_chk(1, 1, 1, 1, 4'hF, "R2 max prev");
    endtask

    task automatic t_three();
        strobe_chk(-1, -1, 0, 500, 4'b0111, "R7 third down");
        strobe_chk(-1, -1, -3, 0, 4'b1101, "R7 neg round");
        strobe_chk(-10, -3, -8, 0, 4'b1110, "R7 nearest");
        strobe_chk(1, 1, 0, 0, 4'b1011, "R7 pos round");
    endtask

    task automatic t_two();
        strobe_chk(-3, 900, -4, 900, 4'b0101, "R6 floor half");
        strobe_chk(-1, 2047, -2048, -2048, 4'b1001, "R6 corner");
    endtask

    task automatic t_absent();
        strobe_chk(-100, 2047, -100, -2048, 4'b0101, "R8 absent ignored");
        strobe_chk(-20, -2048, -40, -60, 4'b1101, "R8 absent three");
    endtask

    task automatic t_invalid();
        strobe_chk(-50, -60, -70, -80, 4'b0001, "R9 single");
        strobe_chk(-50, -60, -70, -80, 4'b0000, "R9 none");
        strobe_chk(-8, -8, -8, -8, 4'hF, "R9 recover");
    endtask

    task automatic t_hold();
        logic [W-1:0] e_hold, t_hold_v;
        strobe_chk(100, 100, 100, 100, 4'hF, "R3 prime");
        e_hold = eff_avg;
        t_hold_v = true_avg;
        @(negedge clk);
        set_err(500, 500, -500, 500);
        repeat (3) @(negedge clk);
        check("R10 eff hold", int'(eff_avg), int'(e_hold));
        check("R10 true hold", int'(true_avg), int'(t_hold_v));
        strobe_chk(50, 50, 50, 50, 4'hF, "R3 no update between strobes");
    endtask

    task automatic t_sweep();
        logic [31:0] lf;
        logic [3:0] masks [6];
        masks[0] = 4'hF; masks[1] = 4'b0111; masks[2] = 4'b0011;
        masks[3] = 4'b1010; masks[4] = 4'b1110; masks[5] = 4'b1001;
        lf = 32'h1ACE_B00C;
        for (int n = 0; n < 200; n++) begin
            int v [4];
            for (int i = 0; i < 4; i++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                v[i] = int'($signed(lf[11:0]));
            end
            strobe_chk(v[0], v[1], v[2], v[3], masks[n % 6], "R4 sweep");
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) prev_m[i] = 0;
        repeat (3) @(negedge clk);
        t_reset_pre();
    end

    task automatic t_reset_pre();
        check("R1 eff in reset", $signed(eff_avg), 0);
        check("R1 cfg in reset", int'(cfg_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_four();
        t_substitute();
        t_three();
        t_two();
        t_absent();
        t_invalid();
        t_hold();
        t_sweep();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule